// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block takes a 32-bit write to the software interrupt generation register from one CPU and carries it out. The write names an interrupt number, a list of target CPUs and a filter mode. The filter mode decides which CPUs actually receive the interrupt. For each chosen target, the interrupt becomes pending. The requesting CPU's bit is also ORed into a source bitmap that is kept separately for every (target, interrupt) pair. Up to 8 CPUs are supported. An input gives the number of CPUs that are currently online.

A downstream slot allocator reads the source bitmaps. As it delivers each (target, interrupt, source) triple, it clears the matching bit through a clear port. The pending flag for an interrupt on a target stays set while any of its source bits remain. It drops in the same edge that removes the last source bit. Reads of the generation register always return zero.

The write port is a valid/ready stream. The block never applies back-pressure: ready is held high, and every cycle with valid high is one accepted write. That write takes effect at the next rising clock edge. The clear port is a plain strobe with no handshake.

Top module: `sgi_dispatch`

## Requirements
- R1: While reset is asserted and right after it is released, every source bit and every pending flag is zero, and `wr_ready_o` is high.
- R2: The write word uses bits [3:0] for the interrupt number, bits [23:16] for the target list (bit n is CPU n) and bits [25:24] for the filter mode. In mode 0 with a non-empty list, every listed CPU that is below `online_i` becomes a target. One cycle after `wr_valid_i` is high, each target has the interrupt's pending flag set and the requester's bit set in its source bitmap.
- R3: In mode 0 with an all-zero list, the write changes no source bit and no pending flag.
- R4: Mode 1 targets every online CPU except the requester.
- R5: Mode 2 targets only the requesting CPU.
- R6: Mode 3 is reserved, and a write in that mode changes nothing.
- R7: `rd_data_o` reads zero in every cycle.
- R8: A strobe on `clr_valid_i` clears exactly one source bit, selected by the target, interrupt and source inputs, at the next edge. All other bits are left unchanged.
- R9: A pending flag stays high while its source bitmap has any bit set. It falls at the edge where the last source bit is cleared.
- R10: When a dispatch sets the same bit that a clear removes in the same cycle, the bit ends up set and the pending flag stays high.
- R11: Writes from different requesters to the same target and interrupt accumulate: each one ORs in its own source bit.
- R12: Output layout: `src_map_o` bit `((t*NIRQ)+i)*NCPU+s` is source `s` for target `t` and interrupt `i`. `pend_o` bit `t*NIRQ+i` is the pending flag for target `t` and interrupt `i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| online_i | input | 4 | Number of online CPUs, 1..NCPU |
| wr_valid_i | input | 1 | Generation register write present |
| wr_ready_o | output | 1 | Always high; write accepted |
| wr_cpu_i | input | 3 | Requesting CPU |
| wr_data_i | input | 32 | Written word |
| rd_data_o | output | 32 | Read value of the generation register (zero) |
| clr_valid_i | input | 1 | Source clear strobe |
| clr_target_i | input | 3 | Target CPU of the clear |
| clr_irq_i | input | 4 | Interrupt number of the clear |
| clr_src_i | input | 3 | Source CPU bit to clear |
| src_map_o | output | 1024 | Source bitmaps, layout per R12 |
| pend_o | output | 128 | Pending flags, layout per R12 |

## Verification
The assertions assume the following about the inputs:
- `online_i` lies between 1 and NCPU.
- The requesting CPU is below `online_i`.
- The clear indices address existing targets, interrupts and sources.

The no-effect properties are only claimed in cycles without a concurrent clear. The stimulus draws the online count first, then draws the requester below it, and only ever issues clears with in-range indices. Directed cycles isolate each mode from clears, and the collision case is driven on purpose in a separate cycle.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int WORD_W   = 32;
  localparam int IRQ_LSB  = 0;
  localparam int LIST_LSB = 16;
  localparam int LIST_W   = 8;
  localparam int MODE_LSB = 24;
  localparam int MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } flt_mode_e;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int NCPU  = 8,
  parameter int CPU_W = $clog2(NCPU),
  parameter int CNT_W = $clog2(NCPU + 1)
) (
  input  flt_mode_e         mode_i,
  input  logic [NCPU-1:0]   list_i,
  input  logic [CPU_W-1:0]  self_i,
  input  logic [CNT_W-1:0]  online_i,
  output logic [NCPU-1:0]   target_o
);
  logic [NCPU-1:0] online_mask;
  logic [NCPU-1:0] self_mask;

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      online_mask[c] = (CNT_W'(c) < online_i);
    end
    self_mask         = '0;
    self_mask[self_i] = 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      FLT_LIST:   target_o = list_i & online_mask;
      FLT_OTHERS: target_o = online_mask & ~self_mask;
      FLT_SELF:   target_o = self_mask;
      FLT_RSVD:   target_o = '0;
      default:    target_o = '0;
    endcase
  end
endmodule

// File: rtl/sgi_src_cell.sv
module sgi_src_cell #(
  parameter int NCPU = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en_i,
  input  logic [NCPU-1:0] set_oh_i,
  input  logic            clr_en_i,
  input  logic [NCPU-1:0] clr_oh_i,
  output logic [NCPU-1:0] src_o,
  output logic            pend_o
);
  logic [NCPU-1:0] src_q, src_d;
  logic            pend_q, pend_d;

  always_comb begin
    src_d = src_q;
    if (clr_en_i) src_d = src_d & ~clr_oh_i;
    if (set_en_i) src_d = src_d | set_oh_i;
    pend_d = pend_q;
    if (set_en_i) pend_d = 1'b1;
    else if (clr_en_i && (src_d == '0)) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      pend_q <= pend_d;
    end
  end

  assign src_o  = src_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NCPU  = 8,
  parameter int NIRQ  = 16,
  parameter int CPU_W = $clog2(NCPU),
  parameter int IRQ_W = $clog2(NIRQ),
  parameter int CNT_W = $clog2(NCPU + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          online_i,
  input  logic                      wr_valid_i,
  output logic                      wr_ready_o,
  input  logic [CPU_W-1:0]          wr_cpu_i,
  input  logic [WORD_W-1:0]         wr_data_i,
  output logic [WORD_W-1:0]         rd_data_o,
  input  logic                      clr_valid_i,
  input  logic [CPU_W-1:0]          clr_target_i,
  input  logic [IRQ_W-1:0]          clr_irq_i,
  input  logic [CPU_W-1:0]          clr_src_i,
  output logic [NCPU*NIRQ*NCPU-1:0] src_map_o,
  output logic [NCPU*NIRQ-1:0]      pend_o
);
  localparam int CELLS = NCPU * NIRQ;

  flt_mode_e        mode;
  logic [NCPU-1:0]  list;
  logic [IRQ_W-1:0] irq;
  logic [NCPU-1:0]  tgt_mask;
  logic [NCPU-1:0]  req_oh;
  logic [NCPU-1:0]  clr_oh;
  logic             accept;

  assign wr_ready_o = 1'b1;
  assign rd_data_o  = '0;
  assign accept     = wr_valid_i & wr_ready_o;

  assign mode = flt_mode_e'(wr_data_i[MODE_LSB +: MODE_W]);
  assign list = wr_data_i[LIST_LSB +: NCPU];
  assign irq  = wr_data_i[IRQ_LSB +: IRQ_W];

  always_comb begin
    req_oh           = '0;
    req_oh[wr_cpu_i] = 1'b1;
    clr_oh            = '0;
    clr_oh[clr_src_i] = 1'b1;
  end

  sgi_target_decode #(.NCPU(NCPU), .CPU_W(CPU_W), .CNT_W(CNT_W)) u_decode (
    .mode_i   (mode),
    .list_i   (list),
    .self_i   (wr_cpu_i),
    .online_i (online_i),
    .target_o (tgt_mask)
  );

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    for (genvar i = 0; i < NIRQ; i++) begin : g_irq
      localparam int IDX = t * NIRQ + i;
      logic set_en, clr_en;
      assign set_en = accept && tgt_mask[t] && (irq == IRQ_W'(i));
      assign clr_en = clr_valid_i && (clr_target_i == CPU_W'(t))
                      && (clr_irq_i == IRQ_W'(i));
      sgi_src_cell #(.NCPU(NCPU)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (set_en),
        .set_oh_i (req_oh),
        .clr_en_i (clr_en),
        .clr_oh_i (clr_oh),
        .src_o    (src_map_o[IDX*NCPU +: NCPU]),
        .pend_o   (pend_o[IDX])
      );
    end
  end

  if (CELLS < 1) begin : g_bad_size
    initial $error("sgi_dispatch needs at least one cell");
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCPU  = 8,
  parameter int NIRQ  = 16,
  parameter int CPU_W = $clog2(NCPU),
  parameter int IRQ_W = $clog2(NIRQ),
  parameter int CNT_W = $clog2(NCPU + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_valid_i,
  input logic [CPU_W-1:0]          wr_cpu_i,
  input logic [31:0]               wr_data_i,
  input logic                      clr_valid_i,
  input logic [CPU_W-1:0]          clr_target_i,
  input logic [IRQ_W-1:0]          clr_irq_i,
  input logic [CPU_W-1:0]          clr_src_i,
  input logic [NCPU*NIRQ*NCPU-1:0] src_map_o,
  input logic [NCPU*NIRQ-1:0]      pend_o
);
  logic [1:0]       mode;
  logic [7:0]       list;
  logic [IRQ_W-1:0] irq;
  int               self_idx;
  int               clr_idx;

  assign mode     = wr_data_i[25:24];
  assign list     = wr_data_i[23:16];
  assign irq      = wr_data_i[IRQ_W-1:0];
  assign self_idx = (int'(wr_cpu_i) * NIRQ + int'(irq)) * NCPU + int'(wr_cpu_i);
  assign clr_idx  = (int'(clr_target_i) * NIRQ + int'(clr_irq_i)) * NCPU + int'(clr_src_i);

  AST_EMPTY_LIST_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && mode == 2'd0 && list == 8'd0 && !clr_valid_i)
      |=> ($stable(src_map_o) && $stable(pend_o))); // R3

  AST_OTHERS_SKIP_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && mode == 2'd1 && !clr_valid_i)
      |=> (src_map_o[$past(self_idx)] == $past(src_map_o[self_idx]))); // R4

  AST_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && mode == 2'd2) |=> src_map_o[$past(self_idx)]); // R5

  AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && mode == 2'd3 && !clr_valid_i)
      |=> ($stable(src_map_o) && $stable(pend_o))); // R6

  AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid_i && !wr_valid_i) |=> !src_map_o[$past(clr_idx)]); // R8

  for (genvar k = 0; k < NCPU * NIRQ; k++) begin : g_pend
    AST_PEND_TRACKS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[k] == (|src_map_o[k*NCPU +: NCPU])); // R9
  end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(
  .NCPU(NCPU), .NIRQ(NIRQ), .CPU_W(CPU_W), .IRQ_W(IRQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid_i   (wr_valid_i),
  .wr_cpu_i     (wr_cpu_i),
  .wr_data_i    (wr_data_i),
  .clr_valid_i  (clr_valid_i),
  .clr_target_i (clr_target_i),
  .clr_irq_i    (clr_irq_i),
  .clr_src_i    (clr_src_i),
  .src_map_o    (src_map_o),
  .pend_o       (pend_o)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
  localparam int NC = 8;
  localparam int NI = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       online = 4'd8;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [2:0]       wr_cpu = '0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      rd_data;
  logic             clr_valid = 1'b0;
  logic [2:0]       clr_target = '0;
  logic [3:0]       clr_irq = '0;
  logic [2:0]       clr_src = '0;
  logic [NC*NI*NC-1:0] src_map;
  logic [NC*NI-1:0]    pend;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] m_src  [NC][NI];
  bit         m_pend [NC][NI];

  always #5 clk = ~clk;

  sgi_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .online_i(online),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_cpu_i(wr_cpu),
    .wr_data_i(wr_data), .rd_data_o(rd_data),
    .clr_valid_i(clr_valid), .clr_target_i(clr_target), .clr_irq_i(clr_irq),
    .clr_src_i(clr_src), .src_map_o(src_map), .pend_o(pend)
  );

  function automatic logic [7:0] targets(input logic [31:0] d, input int self, input int n);
    logic [7:0] on = 8'((1 << n) - 1);
    case (d[25:24])
      2'd0: return d[23:16] & on;
      2'd1: return on & ~8'(1 << self);
      2'd2: return 8'(1 << self);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] word(input int mode, input logic [7:0] lst, input int irq);
    return (32'(mode) << 24) | (32'(lst) << 16) | 32'(irq);
  endfunction

  task automatic compare(input string tag);
    bit bad = 0;
    n_tests++;
    for (int t = 0; t < NC; t++) begin
      for (int i = 0; i < NI; i++) begin
        if (!bad && (src_map[((t*NI)+i)*NC +: NC] !== m_src[t][i]
                     || pend[t*NI+i] !== m_pend[t][i])) begin
          bad = 1;
          $display("FAIL %s t=%0d irq=%0d src=%h pend=%b expected src=%h pend=%b",
                   tag, t, i, src_map[((t*NI)+i)*NC +: NC], pend[t*NI+i],
                   m_src[t][i], m_pend[t][i]);
        end
      end
    end
    if (bad) n_fail++;
    n_tests++;
    if (rd_data !== 32'd0 || wr_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R7 rd_data=%h ready=%b expected 00000000 1", rd_data, wr_ready);
    end
  endtask

  task automatic cyc(input bit wv, input int wc, input logic [31:0] wd,
                     input bit cv, input int ct, input int ci, input int cs,
                     input string tag);
    logic [7:0] tg;
    wr_valid = wv; wr_cpu = 3'(wc); wr_data = wd;
    clr_valid = cv; clr_target = 3'(ct); clr_irq = 4'(ci); clr_src = 3'(cs);
    @(posedge clk);
    if (cv) begin
      m_src[ct][ci][cs] = 1'b0;
      if (m_src[ct][ci] == 8'h00) m_pend[ct][ci] = 0;
    end
    if (wv) begin
      tg = targets(wd, wc, int'(online));
      for (int t = 0; t < NC; t++) begin
        if (tg[t]) begin
          m_src[t][wd[3:0]][wc] = 1'b1;
          m_pend[t][wd[3:0]] = 1;
        end
      end
    end
    @(negedge clk);
    wr_valid = 0; clr_valid = 0;
    compare(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NC; t++)
      for (int i = 0; i < NI; i++) begin
        m_src[t][i] = '0; m_pend[t][i] = 0;
      end
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    online = 4'd8;
    cyc(1, 2, word(0, 8'h12, 5), 0, 0, 0, 0, "R2");
    online = 4'd4;
    cyc(1, 0, word(0, 8'hF2, 3), 0, 0, 0, 0, "R2");
    cyc(1, 0, word(0, 8'h00, 4), 0, 0, 0, 0, "R3");
    cyc(1, 1, word(1, 8'h00, 7), 0, 0, 0, 0, "R4");
    online = 4'd8;
    cyc(1, 3, word(2, 8'hFF, 15), 0, 0, 0, 0, "R5");
    cyc(1, 4, word(3, 8'hFF, 2), 0, 0, 0, 0, "R6");
    cyc(1, 5, word(0, 8'h02, 5), 0, 0, 0, 0, "R11");
    cyc(0, 0, 0, 1, 1, 5, 2, "R8");
    cyc(0, 0, 0, 1, 1, 5, 5, "R9");
    cyc(1, 0, word(0, 8'h40, 9), 0, 0, 0, 0, "R2");
    cyc(1, 6, word(2, 8'h00, 9), 1, 6, 9, 0, "R10");
    cyc(1, 6, word(2, 8'h00, 9), 1, 6, 9, 6, "R10");
    cyc(0, 0, 0, 1, 3, 3, 3, "R8");
    cyc(1, 7, word(1, 8'h00, 0), 0, 0, 0, 0, "R4");
    cyc(1, 7, word(0, 8'hFF, 1), 0, 0, 0, 0, "R12");

    for (int k = 0; k < 400; k++) begin
      int n  = 1 + int'($urandom_range(7));
      int wc = int'($urandom_range(n - 1));
      online = 4'(n);
      cyc(bit'($urandom_range(1)), wc,
          word(int'($urandom_range(3)), 8'($urandom), int'($urandom_range(15))),
          bit'($urandom_range(1)), int'($urandom_range(7)),
          int'($urandom_range(15)), int'($urandom_range(7)), "R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule